// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits right after instruction fetch. It receives a six-byte window taken from byte-addressable memory. Byte 0 of the window is the byte at the current program counter. From this window it works out the fields a decode stage needs: the instruction class, the function code, the two register fields, a 32-bit constant and the instruction length. It also produces the address of the next sequential instruction and flags encodings that are not legal.

The window is packed with its lowest-addressed byte in bits 7:0, the next byte in bits 15:8, and so on up to bits 47:40. The first byte carries the class in its upper nibble and the function code in its lower nibble. The length depends on the class nibble alone, so a fetch unit can use the registered length and next address to step to the next instruction. Results appear one clock after a qualified input. They hold their values while no new input is presented.

Top module: `instr_predecode`

## Requirements
- R1: A synchronous reset clears every output to zero, including the valid flag, whatever the inputs are.
- R2: `out_valid` is `in_valid` from the previous clock cycle. While `in_valid` is low, every data output keeps its previous value.
- R3: For a legal first byte, the length is set by its upper nibble. Classes 0, 1 and 9 are 1 byte long. Classes 2, 6, 0xA and 0xB are 2 bytes long. Classes 7 and 8 are 5 bytes long. Classes 3, 4 and 5 are 6 bytes long.
- R4: `out_next_pc` equals the input PC plus the reported length, modulo 2^PC_W.
- R5: For 2-byte and 6-byte instructions, `out_ra` is the upper nibble of byte 1 and `out_rb` is its lower nibble. For every other case, including illegal encodings, both outputs are 8, which means no register.
- R6: The constant is read little-endian from four bytes. For classes 7 and 8 it starts at byte 1. For classes 3, 4 and 5 it starts at byte 2. For every other case it is zero. Example: the bytes 30 82 cd ab 00 00 give constant 0x0000abcd, `out_ra`=8 and `out_rb`=2.
- R7: `out_bad` is 1 in four cases: the class is above 0xB; the class is 6 and the function is above 3; the class is 7 and the function is above 6; or any other class has a nonzero function. An illegal encoding reports length 1.
- R8: `out_kind` and `out_func` carry the upper and lower nibbles of byte 0 unchanged, whether or not the encoding is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window and PC are valid this cycle |
| pc | input | PC_W | Address of byte 0 of the window |
| win | input | 48 | Fetched bytes, byte 0 in bits 7:0 |
| out_valid | output | 1 | Decoded result valid |
| out_kind | output | 4 | Instruction class nibble |
| out_func | output | 4 | Function code nibble |
| out_ra | output | 4 | First register field, 8 = none |
| out_rb | output | 4 | Second register field, 8 = none |
| out_const | output | 32 | Assembled little-endian constant |
| out_len | output | 3 | Instruction length in bytes |
| out_next_pc | output | PC_W | Address of the next sequential instruction |
| out_bad | output | 1 | Illegal encoding |

## Verification
The cases that are hardest to reach from the ports are an illegal function code on a class that is otherwise legal, and a 6-byte instruction near the top of the address space, where the next address wraps around. Directed steps cover both. They also cover every legal class with its extreme function values and the documented example window. Long random runs mix legal opcodes with arbitrary bytes and idle cycles. These runs show that the registered outputs hold during idle cycles and that a reset in mid-stream clears them.

// File: rtl/instr_predecode.sv
module instr_predecode #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [PC_W-1:0] pc,
  input  logic [47:0]     win,
  output logic            out_valid,
  output logic [3:0]      out_kind,
  output logic [3:0]      out_func,
  output logic [3:0]      out_ra,
  output logic [3:0]      out_rb,
  output logic [31:0]     out_const,
  output logic [2:0]      out_len,
  output logic [PC_W-1:0] out_next_pc,
  output logic            out_bad
);
  localparam logic [3:0] NO_REG = 4'h8;

  logic [3:0]  kind, func, max_fn;
  logic [2:0]  base_len, len;
  logic        known, bad, has_regs;
  logic [31:0] cval;

  assign kind = win[7:4];
  assign func = win[3:0];

  always_comb begin
    base_len = 3'd1;
    max_fn   = 4'd0;
    known    = 1'b1;
    case (kind)
      4'h0, 4'h1, 4'h9:       base_len = 3'd1;
      4'h2, 4'hA, 4'hB:       base_len = 3'd2;
      4'h6: begin             base_len = 3'd2; max_fn = 4'd3; end
      4'h7: begin             base_len = 3'd5; max_fn = 4'd6; end
      4'h8:                   base_len = 3'd5;
      4'h3, 4'h4, 4'h5:       base_len = 3'd6;
      default:                known    = 1'b0;
    endcase
  end

  assign bad      = !known || (func > max_fn);
  assign len      = bad ? 3'd1 : base_len;
  assign has_regs = (len == 3'd2) || (len == 3'd6);
  assign cval     = (len == 3'd5) ? win[39:8] :
                    (len == 3'd6) ? win[47:16] : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_func    <= '0;
      out_ra      <= '0;
      out_rb      <= '0;
      out_const   <= '0;
      out_len     <= '0;
      out_next_pc <= '0;
      out_bad     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind    <= kind;
        out_func    <= func;
        out_ra      <= has_regs ? win[15:12] : NO_REG;
        out_rb      <= has_regs ? win[11:8]  : NO_REG;
        out_const   <= cval;
        out_len     <= len;
        out_next_pc <= pc + PC_W'(len);
        out_bad     <= bad;
      end
    end
  end
endmodule

// File: rtl/instr_predecode_props.sv
module instr_predecode_props #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [PC_W-1:0] pc,
  input logic            out_valid,
  input logic [3:0]      out_ra,
  input logic [3:0]      out_rb,
  input logic [31:0]     out_const,
  input logic [2:0]      out_len,
  input logic [PC_W-1:0] out_next_pc,
  input logic            out_bad
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R2
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_len) && $stable(out_const) && $stable(out_next_pc));  // R2
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd5 || out_len == 3'd6));  // R3
  AST_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_next_pc == $past(pc) + PC_W'(out_len));  // R4
  AST_SHORT_NO_REGS: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 3'd1 |-> out_ra == 4'h8 && out_rb == 4'h8);  // R5
  AST_BAD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_bad |-> out_len == 3'd1 && out_const == 32'd0);  // R7
endmodule

bind instr_predecode instr_predecode_props #(.PC_W(PC_W)) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc),
  .out_valid(out_valid), .out_ra(out_ra), .out_rb(out_rb),
  .out_const(out_const), .out_len(out_len), .out_next_pc(out_next_pc),
  .out_bad(out_bad)
);

// File: tb/instr_predecode_test.sv
module instr_predecode_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, in_valid;
  logic [31:0] pc;
  logic [47:0] win;
  logic        out_valid, out_bad;
  logic [3:0]  out_kind, out_func, out_ra, out_rb;
  logic [31:0] out_const, out_next_pc;
  logic [2:0]  out_len;

  instr_predecode uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc(pc), .win(win),
    .out_valid(out_valid), .out_kind(out_kind), .out_func(out_func),
    .out_ra(out_ra), .out_rb(out_rb), .out_const(out_const),
    .out_len(out_len), .out_next_pc(out_next_pc), .out_bad(out_bad)
  );

  int checks = 0;
  int fails  = 0;

  logic        e_valid, e_bad;
  logic [3:0]  e_kind, e_func, e_ra, e_rb;
  logic [31:0] e_const, e_npc;
  logic [2:0]  e_len;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", "valid", out_valid, e_valid);
    check("R8", "kind", out_kind, e_kind);
    check("R8", "func", out_func, e_func);
    check("R5", "ra", out_ra, e_ra);
    check("R5", "rb", out_rb, e_rb);
    check("R6", "const", out_const, e_const);
    check("R3", "len", out_len, e_len);
    check("R4", "next_pc", out_next_pc, e_npc);
    check("R7", "bad", out_bad, e_bad);
  endtask

  task automatic model(input logic r, input logic v, input logic [31:0] p, input logic [47:0] w);
    int t, f, n, off;
    bit illegal;
    logic [31:0] c;
    if (r) begin
      e_valid = 0; e_kind = 0; e_func = 0; e_ra = 0; e_rb = 0;
      e_const = 0; e_len = 0; e_npc = 0; e_bad = 0;
      return;
    end
    e_valid = v;
    if (!v) return;
    t = int'(w[7:4]);
    f = int'(w[3:0]);
    case (t)
      0, 1, 9:        n = 1;
      2, 6, 10, 11:   n = 2;
      7, 8:           n = 5;
      3, 4, 5:        n = 6;
      default:        n = 0;
    endcase
    if (n == 0)      illegal = 1;
    else if (t == 6) illegal = (f > 3);
    else if (t == 7) illegal = (f > 6);
    else             illegal = (f != 0);
    if (illegal) n = 1;
    e_kind = w[7:4];
    e_func = w[3:0];
    e_bad  = illegal;
    e_len  = 3'(n);
    e_npc  = p + 32'(n);
    if (n == 2 || n == 6) begin
      e_ra = w[15:12];
      e_rb = w[11:8];
    end else begin
      e_ra = 4'h8;
      e_rb = 4'h8;
    end
    off = (n == 5) ? 1 : (n == 6) ? 2 : -1;
    c = 0;
    if (off >= 0)
      for (int k = 0; k < 4; k++) c = c | (32'(w[8*(off+k) +: 8]) << (8*k));
    e_const = c;
  endtask

  task automatic step(input logic r, input logic v, input logic [31:0] p, input logic [47:0] w);
    rst = r; in_valid = v; pc = p; win = w;
    model(r, v, p, w);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [7:0] legal_op(input int sel);
    case (sel % 12)
      0:  return 8'h00;
      1:  return 8'h10;
      2:  return 8'h20;
      3:  return 8'h30;
      4:  return 8'h40;
      5:  return 8'h50;
      6:  return 8'h60 | 8'($urandom_range(0, 3));
      7:  return 8'h70 | 8'($urandom_range(0, 6));
      8:  return 8'h80;
      9:  return 8'h90;
      10: return 8'hA0;
      default: return 8'hB0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [47:0] w;
    // R1: reset with valid asserted and junk inputs
    step(1, 1, 32'hDEADBEEF, 48'h123456789A30);
    step(1, 0, 32'h0, 48'h0);
    // R6 R5: documented example at some address
    step(0, 1, 32'h0000_0100, 48'h0000_abcd_8230);
    // R2: idle cycles hold
    step(0, 0, 32'h5555_5555, 48'hFFFF_FFFF_FF60);
    step(0, 0, 32'h0, 48'h0);
    // R3: every legal class with extreme function values
    for (int t = 0; t < 12; t++) begin
      step(0, 1, 32'h1000 + 32'(t*16), {40'hA1B2C3D4E5, 4'(t), 4'h0});
    end
    step(0, 1, 32'h40, 48'h0000_0000_1263);
    step(0, 1, 32'h44, 48'h0000_0020_0076);
    // R7: illegal encodings
    step(0, 1, 32'h80, 48'h1122_3344_55C0);
    step(0, 1, 32'h84, 48'h1122_3344_55F0);
    step(0, 1, 32'h88, 48'h1122_3344_5501);
    step(0, 1, 32'h8C, 48'h1122_3344_5564);
    step(0, 1, 32'h90, 48'h1122_3344_5577);
    step(0, 1, 32'h94, 48'h1122_3344_5521);
    step(0, 1, 32'h98, 48'h1122_3344_5581);
    step(0, 1, 32'h9C, 48'h1122_3344_55B5);
    // R4: address wrap with 6-byte and 5-byte instructions
    step(0, 1, 32'hFFFF_FFFC, 48'h0403_0201_5450);
    step(0, 1, 32'hFFFF_FFFE, 48'h4433_2211_0080);
    // R1: reset in mid-stream
    step(1, 1, 32'h200, 48'h0403_0201_5450);
    step(0, 0, 32'h0, 48'h0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      w = {$urandom(), $urandom()};
      if ($urandom_range(0, 9) < 7) w[7:0] = legal_op(int'($urandom_range(0, 11)));
      step(($urandom_range(0, 199) == 0), ($urandom_range(0, 4) != 0), $urandom(), w);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule